// File: doc/BRIEF.md
# PCI Target Back-End Bridge

This block lets a simple peripheral that has no PCI logic of its own act as a 32-bit PCI target. It watches the bus for the start of each transaction and latches the address, the command and the IDSEL strobe from that single address clock. It claims the transaction when the address falls inside a parameterized window, or when IDSEL was high.

A claimed transaction first asks the peripheral for permission as a whole, through a request/grant pair. Every data phase then gets its own data-request/data-acknowledge exchange before TRDY# is driven. Bursts of any length and single-phase transactions use the same path.

Stalls are handled on both sides. A slow peripheral simply holds off its acknowledge. If the initiator drops IRDY# while TRDY# is asserted, the block parks in a dedicated wait state. Write data and read data travel on AD directly between the bus and the peripheral. The block only gives the peripheral its address, its direction and the AD output enable.

Top module: `pcit_bridge`

## Requirements
- R1: While reset is held and right after it, DEVSEL# and TRDY# are high, and the back-end request, data request and AD output enable are low.
- R2: A transaction starts on a clock where FRAME# is sampled low after being sampled high on the previous clock; that clock's AD, C/BE# and IDSEL are captured. If the captured address lies in [BASE, BASE+WINDOW) or the captured IDSEL was high, DEVSEL# goes low two clocks after that edge and stays low until the end of the transaction.
- R3: On a miss with IDSEL low, DEVSEL#, TRDY# and the back-end request stay inactive, and the remaining cycles of that transaction (FRAME# still low) do not start a new one.
- R4: After a claim, the back-end request is high and held until a grant is sampled. The back-end address shows the captured address. The write flag equals bit 0 of the captured C/BE# code (1 = write, e.g. 0111; 0 = read, e.g. 0110).
- R5: After the grant, no data request is raised until IRDY# is sampled low.
- R6: The data request stays high until an acknowledge is sampled; TRDY# goes low on the clock after that and never while an acknowledge is still pending.
- R7: After a completed data phase that is not the last, TRDY# goes high and the data request is raised again for the next phase.
- R8: If IRDY# is sampled high while TRDY# is low, nothing transfers. TRDY# goes high, DEVSEL# stays low and no new data request is raised. TRDY# returns low on the clock after IRDY# is sampled low again.
- R9: The back-end address advances by 4 after each completed data phase (TRDY# and IRDY# both low).
- R10: A completed data phase with FRAME# high or the back-end stop high ends the transaction. DEVSEL# and TRDY# are high on the next clock and the block is idle one clock later.
- R11: The AD output enable is high only for read transactions while a data request is pending, TRDY# is low or the initiator is stalling. It is never high in the clock after the address phase, nor for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select, sampled in the address phase |
| ad_in | input | ADDR_W | Multiplexed address/data bus as seen by the block |
| cbe_n | input | CMD_W | Command / byte enables; command in the address phase |
| devsel_n | output | 1 | Target claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| ad_oe | output | 1 | Output enable for back-end read data onto AD |
| be_req | output | 1 | Transaction request to the back end |
| be_gnt | input | 1 | Back-end acceptance of the transaction |
| be_dreq | output | 1 | Per-phase data request to the back end |
| be_dack | input | 1 | Back-end data acknowledge |
| be_stop | input | 1 | Back-end request to end the transaction |
| be_addr | output | ADDR_W | Current transfer address for the back end |
| be_wr | output | 1 | 1 = write transaction, 0 = read |

## Verification
The bench targets the window edges (the last word below the base, the base, the last word inside and the first word past the end) and IDSEL claims outside the window. A wrong comparator would claim or drop the wrong one. Misses are followed by several FRAME#-low data cycles, which a design that re-arms on any low FRAME# would treat as a new address. Initiator stalls are placed on the first, middle and last phases, and early back-end stops cut bursts short. A design that retransfers in the wait state, misses the address step or keeps DEVSEL# after the final phase shows up as a wrong TRDY#, address or claim sample in those cycles.

// File: rtl/pcit_pkg.sv
package pcit_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_REQ,
      ST_GNT,
      ST_DREQ,
      ST_DACK,
      ST_WAIT,
      ST_EOT
   } pcit_state_e;

   // bit 0 of a PCI command separates write codes from read codes
   function automatic logic cmd_is_write(input logic cmd_lsb);
      return cmd_lsb;
   endfunction

endpackage

// File: rtl/pcit_win_decode.sv
module pcit_win_decode #(
   parameter int unsigned              ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]        BASE      = '0,
   parameter longint unsigned          WIN_BYTES = 256
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [ADDR_W:0] WIN_L   = WIN_BYTES[ADDR_W:0];
   localparam bit              IS_POW2 = ((WIN_BYTES & (WIN_BYTES - 1)) == 0);
   localparam bit              ALIGNED = ((BASE & (WIN_L[ADDR_W-1:0] - 1'b1)) == '0);

   generate
      if (WIN_BYTES == 0) begin : g_bad_win
         $error("pcit_win_decode: WIN_BYTES must be non-zero");
      end
      if (IS_POW2 && ALIGNED) begin : g_mask
         localparam logic [ADDR_W-1:0] MASK = ~(WIN_L[ADDR_W-1:0] - 1'b1);
         assign hit = ((addr & MASK) == (BASE & MASK));
      end else begin : g_range
         logic [ADDR_W:0] off;
         assign off = {1'b0, addr} - {1'b0, BASE};
         assign hit = !off[ADDR_W] && (off < WIN_L);
      end
   endgenerate
endmodule

// File: rtl/pcit_addr_ctr.sv
module pcit_addr_ctr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              adv,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n)    addr <= '0;
      else if (load) addr <= load_val;
      else if (adv)  addr <= addr + STEP_V;
   end
endmodule

// File: rtl/pcit_seq.sv
module pcit_seq
   import pcit_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   input  logic claim,
   input  logic is_wr,
   input  logic be_gnt,
   input  logic be_dack,
   input  logic be_stop,
   output logic start,
   output logic xfer,
   output logic devsel_n,
   output logic trdy_n,
   output logic be_req,
   output logic be_dreq,
   output logic ad_oe
);
   pcit_state_e st, st_nx;
   logic        frame_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         frame_q <= 1'b1;
      end else begin
         st      <= st_nx;
         frame_q <= frame_n;
      end
   end

   assign start = (st == ST_IDLE) && !frame_n && frame_q;
   assign xfer  = (st == ST_DACK) && !irdy_n;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (start)   st_nx = ST_ADDR;
         ST_ADDR: st_nx = claim ? ST_REQ : ST_IDLE;
         ST_REQ:  if (be_gnt)  st_nx = ST_GNT;
         ST_GNT:  if (!irdy_n) st_nx = ST_DREQ;
         ST_DREQ: if (be_dack) st_nx = ST_DACK;
         ST_DACK: begin
            if (irdy_n)                  st_nx = ST_WAIT;
            else if (frame_n || be_stop) st_nx = ST_EOT;
            else                         st_nx = ST_DREQ;
         end
         ST_WAIT: if (!irdy_n) st_nx = ST_DACK;
         ST_EOT:  st_nx = ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   logic in_data;
   assign in_data  = (st == ST_DREQ) || (st == ST_DACK) || (st == ST_WAIT);
   assign devsel_n = !(in_data || (st == ST_REQ) || (st == ST_GNT));
   assign trdy_n   = (st != ST_DACK);
   assign be_req   = (st == ST_REQ);
   assign be_dreq  = (st == ST_DREQ);
   assign ad_oe    = in_data && !is_wr;
endmodule

// File: rtl/pcit_bridge.sv
module pcit_bridge
   import pcit_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       CMD_W     = 4,
   parameter logic [ADDR_W-1:0] BASE      = 32'h4000_0000,
   parameter longint unsigned   WIN_BYTES = 256,
   parameter int unsigned       ADDR_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              irdy_n,
   input  logic              idsel,
   input  logic [ADDR_W-1:0] ad_in,
   input  logic [CMD_W-1:0]  cbe_n,
   output logic              devsel_n,
   output logic              trdy_n,
   output logic              ad_oe,
   output logic              be_req,
   input  logic              be_gnt,
   output logic              be_dreq,
   input  logic              be_dack,
   input  logic              be_stop,
   output logic [ADDR_W-1:0] be_addr,
   output logic              be_wr
);
   generate
      if (ADDR_W < 8)                          begin : g_bad_aw   $error("ADDR_W too small"); end
      if (CMD_W < 1)                           begin : g_bad_cw   $error("CMD_W must be >= 1"); end
      if ((ADDR_STEP & (ADDR_STEP - 1)) != 0)  begin : g_bad_step $error("ADDR_STEP not a power of two"); end
      if ((BASE % ADDR_STEP) != 0)             begin : g_bad_base $error("BASE not step aligned"); end
   endgenerate

   logic start, xfer, hit, wr_q, idsel_q;
   logic cmd_unused;
   assign cmd_unused = ^cbe_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         idsel_q <= 1'b0;
      end else if (start) begin
         wr_q    <= cmd_is_write(cbe_n[0]);
         idsel_q <= idsel;
      end
   end

   pcit_addr_ctr #(.ADDR_W(ADDR_W), .STEP(ADDR_STEP)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(start), .load_val(ad_in),
      .adv(xfer), .addr(be_addr)
   );

   pcit_win_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .WIN_BYTES(WIN_BYTES)) u_win (
      .addr(be_addr), .hit(hit)
   );

   pcit_seq u_seq (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
      .claim(hit || idsel_q), .is_wr(wr_q), .be_gnt(be_gnt),
      .be_dack(be_dack), .be_stop(be_stop), .start(start), .xfer(xfer),
      .devsel_n(devsel_n), .trdy_n(trdy_n), .be_req(be_req),
      .be_dreq(be_dreq), .ad_oe(ad_oe)
   );

   assign be_wr = wr_q;
endmodule

// File: rtl/pcit_bridge_chk.sv
module pcit_bridge_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic              irdy_n,
   input logic              devsel_n,
   input logic              trdy_n,
   input logic              ad_oe,
   input logic              be_req,
   input logic              be_gnt,
   input logic              be_dreq,
   input logic              be_dack,
   input logic              be_stop,
   input logic [ADDR_W-1:0] be_addr,
   input logic              be_wr
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   a_r2_trdy_inside_claim: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |-> !devsel_n);

   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && !be_gnt) |=> be_req);

   a_r6_no_trdy_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (be_dreq && !be_dack) |=> (be_dreq && trdy_n));

   a_r7_dreq_trdy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      be_dreq |-> trdy_n);

   a_r8_stall_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && irdy_n) |=> (trdy_n && !devsel_n && !be_dreq));

   a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && !irdy_n) |=> (be_addr == $past(be_addr) + STEP_V));

   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n && !irdy_n && (frame_n || be_stop)) |=> (devsel_n && trdy_n));

   a_r11_oe_reads_only: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!be_wr && !devsel_n));
endmodule

bind pcit_bridge pcit_bridge_chk #(.ADDR_W(ADDR_W), .STEP(ADDR_STEP)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
   .devsel_n(devsel_n), .trdy_n(trdy_n), .ad_oe(ad_oe), .be_req(be_req),
   .be_gnt(be_gnt), .be_dreq(be_dreq), .be_dack(be_dack),
   .be_stop(be_stop), .be_addr(be_addr), .be_wr(be_wr)
);

// File: tb/pcit_bridge_tb_top.sv
module pcit_bridge_tb_top;
   localparam logic [31:0] T_BASE = 32'h4000_0000;
   localparam int unsigned T_WIN  = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
   logic [31:0] ad_in = '0;
   logic [3:0]  cbe_n = '0;
   logic be_gnt = 1'b0, be_dack = 1'b0, be_stop = 1'b0;
   logic devsel_n, trdy_n, ad_oe, be_req, be_dreq, be_wr;
   logic [31:0] be_addr;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   pcit_bridge #(.ADDR_W(32), .CMD_W(4), .BASE(T_BASE), .WIN_BYTES(T_WIN), .ADDR_STEP(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
      .ad_in(ad_in), .cbe_n(cbe_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
      .ad_oe(ad_oe), .be_req(be_req), .be_gnt(be_gnt), .be_dreq(be_dreq),
      .be_dack(be_dack), .be_stop(be_stop), .be_addr(be_addr), .be_wr(be_wr)
   );

   function automatic bit in_win(input logic [31:0] a);
      return (a >= T_BASE) && (a < T_BASE + T_WIN);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // stp: phase index where the back end asks to stop (-1 = never)
   // wph: phase index where the initiator stalls (-1 = never)
   task automatic run_txn(input logic [31:0] a, input logic [3:0] cmd, input bit sel,
                          input int nph, input int gd, input int idly, input int dd,
                          input int wph, input int wlen, input int stp);
      bit hit = in_win(a) || sel;
      bit wr  = cmd[0];
      @(negedge clk);
      frame_n = 1'b0; ad_in = a; cbe_n = cmd; idsel = sel; irdy_n = 1'b1;
      @(negedge clk);
      chk("R11", "oe in turnaround", {31'b0, ad_oe}, 0);
      chk("R2", "devsel in decode clock", {31'b0, devsel_n}, 1);
      ad_in = $urandom; cbe_n = 4'h0; idsel = 1'b0;
      @(negedge clk);
      if (!hit) begin
         irdy_n = 1'b0;
         for (int i = 0; i < 4; i++) begin
            chk("R3", "devsel on miss", {31'b0, devsel_n}, 1);
            chk("R3", "request on miss", {31'b0, be_req}, 0);
            chk("R3", "trdy on miss", {31'b0, trdy_n}, 1);
            @(negedge clk);
         end
         frame_n = 1'b1; irdy_n = 1'b1;
         @(negedge clk);
         chk("R3", "devsel after miss", {31'b0, devsel_n}, 1);
         return;
      end
      chk("R2", "devsel on claim", {31'b0, devsel_n}, 0);
      chk("R4", "request on claim", {31'b0, be_req}, 1);
      chk("R4", "back-end address", be_addr, a);
      chk("R4", "write flag", {31'b0, be_wr}, {31'b0, wr});
      chk("R11", "oe before data", {31'b0, ad_oe}, 0);
      for (int i = 0; i < gd; i++) begin
         @(negedge clk);
         chk("R4", "request held", {31'b0, be_req}, 1);
      end
      be_gnt = 1'b1;
      @(negedge clk);
      be_gnt = 1'b0;
      chk("R4", "request drops after grant", {31'b0, be_req}, 0);
      chk("R5", "no data request before irdy", {31'b0, be_dreq}, 0);
      for (int i = 0; i < idly; i++) begin
         @(negedge clk);
         chk("R5", "no data request while irdy high", {31'b0, be_dreq}, 0);
      end
      irdy_n = 1'b0;
      @(negedge clk);
      for (int p = 0; p < nph; p++) begin
         bit last = (p == nph - 1) || (p == stp);
         chk(p == 0 ? "R5" : "R7", "data request raised", {31'b0, be_dreq}, 1);
         chk("R7", "trdy off between phases", {31'b0, trdy_n}, 1);
         chk("R11", "oe in data request", {31'b0, ad_oe}, {31'b0, !wr});
         chk("R9", "phase address", be_addr, a + 32'(4 * p));
         for (int i = 0; i < dd; i++) begin
            @(negedge clk);
            chk("R6", "request held for ack", {31'b0, be_dreq}, 1);
            chk("R6", "trdy waits for ack", {31'b0, trdy_n}, 1);
         end
         be_dack = 1'b1;
         @(negedge clk);
         be_dack = 1'b0;
         chk("R6", "trdy after ack", {31'b0, trdy_n}, 0);
         chk("R6", "request cleared", {31'b0, be_dreq}, 0);
         chk("R11", "oe with trdy", {31'b0, ad_oe}, {31'b0, !wr});
         if (p == wph) begin
            irdy_n = 1'b1;
            for (int i = 0; i < wlen + 1; i++) begin
               @(negedge clk);
               chk("R8", "trdy off in stall", {31'b0, trdy_n}, 1);
               chk("R8", "no request in stall", {31'b0, be_dreq}, 0);
               chk("R8", "devsel in stall", {31'b0, devsel_n}, 0);
               chk("R8", "address frozen", be_addr, a + 32'(4 * p));
            end
            irdy_n = 1'b0;
            @(negedge clk);
            chk("R8", "trdy back after stall", {31'b0, trdy_n}, 0);
         end
         frame_n = (p == nph - 1);
         be_stop = (p == stp);
         @(negedge clk);
         be_stop = 1'b0;
         chk("R9", "address after phase", be_addr, a + 32'(4 * (p + 1)));
         if (last) begin
            chk("R10", "devsel released", {31'b0, devsel_n}, 1);
            chk("R10", "trdy released", {31'b0, trdy_n}, 1);
            chk("R11", "oe off at end", {31'b0, ad_oe}, 0);
            frame_n = 1'b1; irdy_n = 1'b1;
            @(negedge clk);
            chk("R10", "idle devsel", {31'b0, devsel_n}, 1);
            chk("R10", "idle request", {31'b0, be_req | be_dreq}, 0);
            return;
         end
      end
   endtask

   function automatic logic [3:0] pick_cmd(input int sel);
      case (sel % 6)
         0: return 4'b0110;
         1: return 4'b0111;
         2: return 4'b0010;
         3: return 4'b0011;
         4: return 4'b1010;
         default: return 4'b1011;
      endcase
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      chk("R1", "devsel in reset", {31'b0, devsel_n}, 1);
      chk("R1", "trdy in reset", {31'b0, trdy_n}, 1);
      chk("R1", "outputs in reset", {29'b0, be_req, be_dreq, ad_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "devsel after reset", {31'b0, devsel_n}, 1);
      chk("R1", "outputs after reset", {29'b0, be_req, be_dreq, ad_oe}, 0);

      // directed: single read, burst write, window edges, IDSEL, stalls, stop
      run_txn(T_BASE, 4'b0110, 1'b0, 1, 0, 0, 0, -1, 0, -1);
      run_txn(T_BASE + 32'h10, 4'b0111, 1'b0, 4, 1, 2, 1, -1, 0, -1);
      run_txn(T_BASE - 32'd4, 4'b0110, 1'b0, 2, 0, 0, 0, -1, 0, -1);
      run_txn(T_BASE + T_WIN, 4'b0111, 1'b0, 2, 0, 0, 0, -1, 0, -1);
      run_txn(T_BASE + T_WIN - 32'd4, 4'b0110, 1'b0, 1, 0, 0, 0, -1, 0, -1);
      run_txn(32'h0000_0800, 4'b1010, 1'b1, 1, 2, 1, 0, -1, 0, -1);
      run_txn(T_BASE + 32'h40, 4'b0110, 1'b0, 4, 0, 0, 0, 0, 2, -1);
      run_txn(T_BASE + 32'h40, 4'b0111, 1'b0, 4, 0, 0, 2, 3, 0, -1);
      run_txn(T_BASE + 32'h80, 4'b0110, 1'b0, 4, 0, 0, 0, 1, 1, 1);
      run_txn(T_BASE + 32'h80, 4'b0111, 1'b0, 1, 0, 0, 0, 0, 3, -1);

      // constrained random
      for (int n = 0; n < 60; n++) begin
         logic [31:0] a;
         int np;
         a = (($urandom % 4) != 0) ? (T_BASE + (($urandom % (T_WIN / 4)) * 4))
                                   : (($urandom & 32'hFFFF_FFFC) ^ 32'h8000_0000);
         np = 1 + ($urandom % 4);
         run_txn(a, pick_cmd($urandom), (($urandom % 8) == 0), np,
                 $urandom % 4, $urandom % 3, $urandom % 4,
                 (($urandom % 3) == 0) ? int'($urandom % np) : -1, $urandom % 3,
                 (($urandom % 5) == 0) ? int'($urandom % np) : -1);
      end

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule